// File: doc/BRIEF.md
# SATA Host Out-of-Band Link Initializer

This block brings up the link of one SATA host port. A port-reset request starts a handshake that runs over an abstracted PHY. The block asks the PHY for a reset burst, waits for the device to answer with its init burst, asks for a wake burst, and then waits for the device's own wake burst. After that it looks for ALIGN primitives, first at the fast line rate and then at the slow one. Each burst request stays high until the PHY reports that the burst has finished.

When ALIGN is decoded, the block raises link-ready and reports the rate that worked. The first device-to-host FIS that arrives while the link is ready is stored as the device signature. A device init burst that arrives at any point other than just after a reset burst is treated as unsolicited. It throws the port back to the start of the handshake and clears everything that the bring-up produced.

Timeouts are counted in clock cycles and set by parameters, so the same logic can be run with short windows in simulation and with real timeouts on silicon.

Top module: `sata_oob_init`

## Requirements
- R1: After the synchronous reset `rst`, both burst requests are low, `linkReady` is 0, `negSpeed` is 2'b00, `sigCaptured` is 0 and `rateSel` is 1 (fast rate). No burst is requested until `portResetReq` is seen.
- R2: One cycle after `portResetReq` is sampled high, `phyComresetReq` is high. It stays high until `phyBurstDone` is sampled, and it goes low in the cycle after that.
- R3: If no `phyCominit` arrives within RESET_TIMEOUT cycles after the reset burst completes, `phyComresetReq` rises again in the next cycle. A `phyCominit` in the last cycle of that window still counts as an answer.
- R4: A `phyCominit` sampled in the wait-for-init window makes `phyComwakeReq` high in the next cycle. It stays high until `phyBurstDone` is sampled.
- R5: After the wake burst completes, a sampled `phyComwakeDet` starts the ALIGN search at `rateSel`=1. If `phyAlignDet` is sampled within the first ALIGN_WINDOW cycles, then in the next cycle `linkReady`=1 and `negSpeed`=2'b10 (3.0 Gbps).
- R6: If no ALIGN arrives within ALIGN_WINDOW cycles at the fast rate, `rateSel` drops to 0 and a second window of the same length starts. An ALIGN in that window gives `linkReady`=1 and `negSpeed`=2'b01 (1.5 Gbps). If the second window also expires, `phyComresetReq` rises with `rateSel` back at 1.
- R7: A `phyCominit` sampled while the wake burst is being sent, while waiting for the device wake, while searching for ALIGN, or while the link is ready causes the following in the next cycle: `phyComresetReq` is high, and `linkReady`, `negSpeed` and `sigCaptured` are cleared.
- R8: The first `fisValid` sampled while `linkReady` is 1 loads `fisData` into `sigReg` and sets `sigCaptured`. A FIS sampled before the link is ready is not stored. A FIS after the capture leaves `sigReg` unchanged.
- R9: `portResetReq` restarts the handshake from any state and clears `linkReady`, `negSpeed` and `sigCaptured`. It takes priority over a `phyCominit` in the same cycle.
- R10: `phyComresetReq` and `phyComwakeReq` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| portResetReq | input | 1 | Port-reset request from the register interface |
| phyBurstDone | input | 1 | Pulse: the requested burst has been sent |
| phyCominit | input | 1 | Pulse: device init burst detected |
| phyComwakeDet | input | 1 | Pulse: device wake burst detected |
| phyAlignDet | input | 1 | Pulse: ALIGN decoded at the current rate |
| fisValid | input | 1 | A received device-to-host FIS is present on fisData |
| fisData | input | SIG_W | Signature portion of the received FIS |
| phyComresetReq | output | 1 | Request a reset burst, held until done |
| phyComwakeReq | output | 1 | Request a wake burst, held until done |
| rateSel | output | 1 | Line rate select: 1 = 3.0 Gbps, 0 = 1.5 Gbps |
| linkReady | output | 1 | Link is up |
| negSpeed | output | 2 | Negotiated speed: 00 none, 01 1.5 Gbps, 10 3.0 Gbps |
| sigCaptured | output | 1 | A signature has been stored |
| sigReg | output | SIG_W | Stored device signature |

## Verification
Two collisions are provoked on purpose. In the first, the device init pulse arrives in the very last cycle of the init window, the same cycle in which the timeout would fire a new reset burst; the answer must win and the wake burst must follow. In the second, an ALIGN pulse falls on the last cycle of the fast-rate window, where the rate would drop; the link must come up at 3.0 Gbps. The bench sweeps the arrival cycle of each pulse across its whole window and one cycle past it. The expected outcome for each offset is worked out from the window lengths. A port reset is also issued together with an init pulse, and the result must be a restart.

// File: rtl/sata_oob_pkg.sv
package sata_oob_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND_RESET,
    ST_WAIT_INIT,
    ST_SEND_WAKE,
    ST_WAIT_WAKE,
    ST_WAIT_ALIGN,
    ST_READY
  } oobState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic restart;    // back to start: clear results, fast rate, clear timer
    logic timerClr;   // restart the window counter
    logic rateDrop;   // fall back to the slow rate
    logic speedLoad;  // record the current rate as negotiated
    logic sigArm;     // link is ready, a FIS may be captured
  } oobStrobe_t;

  localparam logic [1:0] SPD_NONE = 2'b00;
  localparam logic [1:0] SPD_1G5  = 2'b01;
  localparam logic [1:0] SPD_3G   = 2'b10;

endpackage

// File: rtl/oob_ctrl.sv
module oob_ctrl
  import sata_oob_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       portResetReq,
  input  logic       phyBurstDone,
  input  logic       phyCominit,
  input  logic       phyComwakeDet,
  input  logic       phyAlignDet,
  input  logic       initExpired,
  input  logic       alignExpired,
  input  logic       rateIsHigh,
  output oobStrobe_t stb,
  output logic       phyComresetReq,
  output logic       phyComwakeReq,
  output logic       linkReady
);

  oobState_t state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    stb.sigArm = (state == ST_READY);
    if (portResetReq) begin
      nextState   = ST_SEND_RESET;
      stb.restart = 1'b1;
    end else begin
      case (state)
        ST_SEND_RESET: begin
          if (phyBurstDone) begin
            nextState    = ST_WAIT_INIT;
            stb.timerClr = 1'b1;
          end
        end
        ST_WAIT_INIT: begin
          if (phyCominit) begin
            nextState = ST_SEND_WAKE;
          end else if (initExpired) begin
            nextState   = ST_SEND_RESET;
            stb.restart = 1'b1;
          end
        end
        ST_SEND_WAKE: begin
          if (phyCominit) begin
            nextState   = ST_SEND_RESET;
            stb.restart = 1'b1;
          end else if (phyBurstDone) begin
            nextState = ST_WAIT_WAKE;
          end
        end
        ST_WAIT_WAKE: begin
          if (phyCominit) begin
            nextState   = ST_SEND_RESET;
            stb.restart = 1'b1;
          end else if (phyComwakeDet) begin
            nextState    = ST_WAIT_ALIGN;
            stb.timerClr = 1'b1;
          end
        end
        ST_WAIT_ALIGN: begin
          if (phyCominit) begin
            nextState   = ST_SEND_RESET;
            stb.restart = 1'b1;
          end else if (phyAlignDet) begin
            nextState     = ST_READY;
            stb.speedLoad = 1'b1;
          end else if (alignExpired) begin
            if (rateIsHigh) begin
              stb.rateDrop = 1'b1;
              stb.timerClr = 1'b1;
            end else begin
              nextState   = ST_SEND_RESET;
              stb.restart = 1'b1;
            end
          end
        end
        ST_READY: begin
          if (phyCominit) begin
            nextState   = ST_SEND_RESET;
            stb.restart = 1'b1;
          end
        end
        default: nextState = state;
      endcase
    end
  end

  assign phyComresetReq = (state == ST_SEND_RESET);
  assign phyComwakeReq  = (state == ST_SEND_WAKE);
  assign linkReady      = (state == ST_READY);

endmodule

// File: rtl/oob_datapath.sv
module oob_datapath
  import sata_oob_pkg::*;
#(
  parameter int RESET_TIMEOUT = 4,
  parameter int ALIGN_WINDOW  = 3,
  parameter int SIG_W         = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  oobStrobe_t       stb,
  input  logic             fisValid,
  input  logic [SIG_W-1:0] fisData,
  output logic             initExpired,
  output logic             alignExpired,
  output logic             rateSel,
  output logic [1:0]       negSpeed,
  output logic             sigCaptured,
  output logic [SIG_W-1:0] sigReg
);

  localparam int MAX_T = (RESET_TIMEOUT > ALIGN_WINDOW) ? RESET_TIMEOUT : ALIGN_WINDOW;
  localparam int TW    = $clog2(MAX_T + 1);

  logic [TW-1:0] timer;

  always_ff @(posedge clk) begin
    if (rst || stb.restart || stb.timerClr) timer <= '0;
    else                                    timer <= timer + 1'b1;
  end

  assign initExpired  = (timer == TW'(RESET_TIMEOUT - 1));
  assign alignExpired = (timer == TW'(ALIGN_WINDOW - 1));

  always_ff @(posedge clk) begin
    if (rst || stb.restart) begin
      rateSel     <= 1'b1;
      negSpeed    <= SPD_NONE;
      sigCaptured <= 1'b0;
    end else begin
      if (stb.rateDrop)  rateSel  <= 1'b0;
      if (stb.speedLoad) negSpeed <= rateSel ? SPD_3G : SPD_1G5;
      if (stb.sigArm && fisValid && !sigCaptured) sigCaptured <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sigReg <= '0;
    else if (!stb.restart && stb.sigArm && fisValid && !sigCaptured) sigReg <= fisData;
  end

endmodule

// File: rtl/sata_oob_init.sv
module sata_oob_init
  import sata_oob_pkg::*;
#(
  parameter int RESET_TIMEOUT = 4,
  parameter int ALIGN_WINDOW  = 3,
  parameter int SIG_W         = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             portResetReq,
  input  logic             phyBurstDone,
  input  logic             phyCominit,
  input  logic             phyComwakeDet,
  input  logic             phyAlignDet,
  input  logic             fisValid,
  input  logic [SIG_W-1:0] fisData,
  output logic             phyComresetReq,
  output logic             phyComwakeReq,
  output logic             rateSel,
  output logic             linkReady,
  output logic [1:0]       negSpeed,
  output logic             sigCaptured,
  output logic [SIG_W-1:0] sigReg
);

  oobStrobe_t stb;
  logic       initExpired;
  logic       alignExpired;

  oob_ctrl u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .portResetReq  (portResetReq),
    .phyBurstDone  (phyBurstDone),
    .phyCominit    (phyCominit),
    .phyComwakeDet (phyComwakeDet),
    .phyAlignDet   (phyAlignDet),
    .initExpired   (initExpired),
    .alignExpired  (alignExpired),
    .rateIsHigh    (rateSel),
    .stb           (stb),
    .phyComresetReq(phyComresetReq),
    .phyComwakeReq (phyComwakeReq),
    .linkReady     (linkReady)
  );

  oob_datapath #(
    .RESET_TIMEOUT(RESET_TIMEOUT),
    .ALIGN_WINDOW (ALIGN_WINDOW),
    .SIG_W        (SIG_W)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .stb         (stb),
    .fisValid    (fisValid),
    .fisData     (fisData),
    .initExpired (initExpired),
    .alignExpired(alignExpired),
    .rateSel     (rateSel),
    .negSpeed    (negSpeed),
    .sigCaptured (sigCaptured),
    .sigReg      (sigReg)
  );

endmodule

// File: rtl/oob_checker.sv
module oob_checker #(
  parameter int SIG_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             portResetReq,
  input logic             phyBurstDone,
  input logic             phyCominit,
  input logic             phyComresetReq,
  input logic             phyComwakeReq,
  input logic             linkReady,
  input logic [1:0]       negSpeed,
  input logic             sigCaptured,
  input logic [SIG_W-1:0] sigReg
);

  p_reset_held_r2: assert property (@(posedge clk) disable iff (rst)
    phyComresetReq && !phyBurstDone |=> phyComresetReq);

  p_wake_held_r4: assert property (@(posedge clk) disable iff (rst)
    phyComwakeReq && !phyBurstDone && !phyCominit && !portResetReq |=> phyComwakeReq);

  p_ready_speed_r5: assert property (@(posedge clk) disable iff (rst)
    linkReady |-> negSpeed != 2'b00);

  p_unsolicited_r7: assert property (@(posedge clk) disable iff (rst)
    linkReady && phyCominit |=> phyComresetReq && !linkReady && negSpeed == 2'b00 && !sigCaptured);

  p_sig_kept_r8: assert property (@(posedge clk) disable iff (rst)
    sigCaptured |=> $stable(sigReg));

  p_restart_r9: assert property (@(posedge clk) disable iff (rst)
    portResetReq |=> phyComresetReq && !linkReady && !sigCaptured);

  p_req_mutex_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({phyComresetReq, phyComwakeReq}));

endmodule

bind sata_oob_init oob_checker #(.SIG_W(SIG_W)) u_oob_checker (
  .clk           (clk),
  .rst           (rst),
  .portResetReq  (portResetReq),
  .phyBurstDone  (phyBurstDone),
  .phyCominit    (phyCominit),
  .phyComresetReq(phyComresetReq),
  .phyComwakeReq (phyComwakeReq),
  .linkReady     (linkReady),
  .negSpeed      (negSpeed),
  .sigCaptured   (sigCaptured),
  .sigReg        (sigReg)
);

// File: tb/tb_sata_oob_init.sv
`timescale 1ns/1ps
module tb_sata_oob_init;

  localparam int RT = 4;
  localparam int AW = 3;
  localparam int SW = 32;

  logic clk = 1'b0;
  logic rst, portResetReq, phyBurstDone, phyCominit, phyComwakeDet, phyAlignDet, fisValid;
  logic [SW-1:0] fisData;
  logic phyComresetReq, phyComwakeReq, rateSel, linkReady, sigCaptured;
  logic [1:0] negSpeed;
  logic [SW-1:0] sigReg;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sata_oob_init #(.RESET_TIMEOUT(RT), .ALIGN_WINDOW(AW), .SIG_W(SW)) dut (
    .clk(clk), .rst(rst), .portResetReq(portResetReq), .phyBurstDone(phyBurstDone),
    .phyCominit(phyCominit), .phyComwakeDet(phyComwakeDet), .phyAlignDet(phyAlignDet),
    .fisValid(fisValid), .fisData(fisData), .phyComresetReq(phyComresetReq),
    .phyComwakeReq(phyComwakeReq), .rateSel(rateSel), .linkReady(linkReady),
    .negSpeed(negSpeed), .sigCaptured(sigCaptured), .sigReg(sigReg)
  );

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual hung run, expected completion");
      summary();
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    check(act === exp, tag, act, exp);
  endtask

  // advance one edge, sample after it; R10 observed every cycle
  task automatic tick();
    @(posedge clk); #1;
    check(!(phyComresetReq && phyComwakeReq), "R10 both requests",
          {phyComresetReq, phyComwakeReq}, 2'b00);
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1; tick(); sig = 1'b0;
  endtask

  // port reset, reset burst done, init answer, wake burst done, device wake
  task automatic toAlignSearch();
    pulse(portResetReq);
    chk("R2 reset burst requested", phyComresetReq, 1);
    pulse(phyBurstDone);
    pulse(phyCominit);
    chk("R4 wake burst requested", phyComwakeReq, 1);
    pulse(phyBurstDone);
    chk("R4 wake burst released", phyComwakeReq, 0);
    pulse(phyComwakeDet);
    chk("R5 search starts fast", rateSel, 1);
  endtask

  initial begin
    rst = 1; portResetReq = 0; phyBurstDone = 0; phyCominit = 0;
    phyComwakeDet = 0; phyAlignDet = 0; fisValid = 0; fisData = '0;
    tick(); tick();
    rst = 0;
    tick();
    // R1 reset state
    chk("R1 comreset", phyComresetReq, 0);
    chk("R1 comwake", phyComwakeReq, 0);
    chk("R1 linkReady", linkReady, 0);
    chk("R1 negSpeed", negSpeed, 2'b00);
    chk("R1 sigCaptured", sigCaptured, 0);
    chk("R1 rateSel", rateSel, 1);
    repeat (3) tick();
    chk("R1 idle without request", phyComresetReq, 0);

    // R2/R3/R4 sweep of init answer offset; k == RT means no answer
    for (int k = 0; k <= RT; k++) begin
      pulse(portResetReq);
      chk("R2 request after port reset", phyComresetReq, 1);
      for (int d = 0; d < (k % 3); d++) begin
        tick();
        chk("R2 request held", phyComresetReq, 1);
      end
      pulse(phyBurstDone);
      chk("R2 request released", phyComresetReq, 0);
      for (int j = 0; j < RT; j++) begin
        if (j == k) begin
          pulse(phyCominit);
          chk("R4 answer gives wake burst", phyComwakeReq, 1);
          chk("R3 answer beats timeout", phyComresetReq, 0);
          break;
        end
        tick();
        if (j == RT - 1) chk("R3 retry after timeout", phyComresetReq, 1);
        else             chk("R3 no retry inside window", phyComresetReq, 0);
      end
      if (k < RT) begin
        tick(); tick();
        chk("R4 wake held until done", phyComwakeReq, 1);
      end
    end

    // R5/R6 sweep of ALIGN offset over both windows; m == 2*AW means none
    for (int m = 0; m <= 2 * AW; m++) begin
      toAlignSearch();
      for (int j = 0; j < 2 * AW; j++) begin
        if (j == m) begin
          pulse(phyAlignDet);
          chk(m < AW ? "R5 link ready fast" : "R6 link ready slow", linkReady, 1);
          chk(m < AW ? "R5 speed 3.0" : "R6 speed 1.5", negSpeed, (m < AW) ? 2'b10 : 2'b01);
          break;
        end
        tick();
        if (j < AW - 1)       chk("R5 still fast", rateSel, 1);
        else if (j < 2*AW - 1) chk("R6 dropped to slow", rateSel, 0);
      end
      if (m == 2 * AW) begin
        chk("R6 restart after both windows", phyComresetReq, 1);
        chk("R6 rate back to fast", rateSel, 1);
        chk("R6 no link", linkReady, 0);
      end
    end

    // R8 signature capture
    toAlignSearch();
    fisValid = 1; fisData = 32'hAAAA0001;
    pulse(phyAlignDet);
    fisValid = 0;
    chk("R8 FIS before ready not stored", sigCaptured, 0);
    fisData = 32'h5A5A1234;
    pulse(fisValid);
    chk("R8 first FIS captured", sigCaptured, 1);
    chk("R8 signature value", sigReg, 32'h5A5A1234);
    fisData = 32'hDEAD0002;
    pulse(fisValid);
    chk("R8 later FIS ignored", sigReg, 32'h5A5A1234);

    // R7 unsolicited init while ready
    pulse(phyCominit);
    chk("R7 restart from ready", phyComresetReq, 1);
    chk("R7 linkReady cleared", linkReady, 0);
    chk("R7 speed cleared", negSpeed, 2'b00);
    chk("R7 signature flag cleared", sigCaptured, 0);

    // R7 unsolicited init while sending wake
    pulse(phyBurstDone);
    pulse(phyCominit);
    chk("R7 in wake send: wake up", phyComwakeReq, 1);
    pulse(phyCominit);
    chk("R7 in wake send: restart", phyComresetReq, 1);
    // R7 while waiting for device wake
    pulse(phyBurstDone);
    pulse(phyCominit);
    pulse(phyBurstDone);
    pulse(phyCominit);
    chk("R7 in wake wait: restart", phyComresetReq, 1);
    // R7 while searching for ALIGN (after drop to slow)
    toAlignSearch();
    repeat (AW) tick();
    chk("R6 slow before unsolicited", rateSel, 0);
    pulse(phyCominit);
    chk("R7 in align search: restart", phyComresetReq, 1);
    chk("R7 rate back fast", rateSel, 1);

    // R9 port reset together with an init answer
    pulse(phyBurstDone);
    portResetReq = 1; phyCominit = 1;
    tick();
    portResetReq = 0; phyCominit = 0;
    chk("R9 port reset wins: reset burst", phyComresetReq, 1);
    chk("R9 port reset wins: no wake", phyComwakeReq, 0);
    // R9 port reset from ready clears results
    toAlignSearch();
    pulse(phyAlignDet);
    fisData = 32'h0BADF00D;
    pulse(fisValid);
    chk("R9 setup captured", sigCaptured, 1);
    pulse(portResetReq);
    chk("R9 restart from ready", phyComresetReq, 1);
    chk("R9 link cleared", linkReady, 0);
    chk("R9 speed cleared", negSpeed, 2'b00);
    chk("R9 flag cleared", sigCaptured, 0);

    summary();
  end

endmodule